// File: doc/BRIEF.md
# Power-On Strap Capture and Clock Mode Controller

This block is the digital control core of a multi-output clock generator. Four package pins do two jobs. While power-on reset is held they are inputs, and their levels select the operating configuration: one pin picks whether the bus clock runs locked to the CPU clock or at a fixed rate, and three pins form a frequency select code. The block stores these four levels in a register. When reset ends, the block enables its output drivers, and the same pins then carry clocks.

The latched code is decoded into one of three states. Six codes pick a normal operating point, which the block reports as a 3-bit index for the external synthesizer. One reserved code selects a production test mode. In that mode the block itself drives every clock group from integer dividers of the reference clock. One other reserved code turns every output driver off, including the reference output. The analog synthesis of the normal frequencies and the pad electrical behaviour sit outside this block. In normal mode the CPU, bus, 48 MHz and 24 MHz clock ports are held low here, and the synthesizer outside supplies those clocks.

Top module: `strap_clock_ctrl`

## Requirements
- R1: While `rst_n` is low, every output enable (`strap_oe`, `cpu_oe`, `bus_oe`, `fix_oe`, `ref_oe`) is 0 and every clock output is 0.
- R2: The register takes `strap_in` on each clock edge while `rst_n` is low, so it holds the value of the last reset cycle, with strap_in[0] = bus select, strap_in[1] = FS0, strap_in[2] = FS1 and strap_in[3] = FS2. After reset, changes on `strap_in` have no effect on any output until the next reset.
- R3: With FS2:FS0 = 111, `mode_o` = 2'b10 and, after reset, every enable and every clock output (including `ref_clk`) stays 0.
- R4: With FS2:FS0 = 011, `mode_o` = 2'b01. Every `cpu_clk` bit and `usb_clk` then have a period of 2 reference cycles, high for 1 cycle. `fd_clk` has a period of 4 cycles, high for 2.
- R5: In test mode with bus select = 1, every `bus_clk` bit has a period of 4 reference cycles, high for 2. With bus select = 0, the period is 3 cycles and the clock is high for 1.5 cycles, made with both edges.
- R6: `ref_clk` equals the reference clock whenever the outputs are enabled, in both normal and test mode.
- R7: In normal modes `mode_o` = 2'b00, and `cpu_idx` maps FS2:FS0 as follows: 000→0 (50 MHz), 001→1 (60 MHz), 010→2 (66.6 MHz), 100→3 (55 MHz), 101→4 (75 MHz), 110→5 (83.3 MHz). In test and off modes `cpu_idx` is 0.
- R8: `bus_sync` is 1 only in a normal mode with bus select = 1, which means a synchronous bus at CPU/2. Otherwise it is 0, which means the fixed asynchronous rate.
- R9: On the first clock edge after reset is released, the enables rise (except in the off code). Every test divider output also rises on that edge, and every later rising edge of `fd_clk` coincides with a rising edge of `cpu_clk`.
- R10: In normal modes `cpu_clk`, `bus_clk`, `usb_clk` and `fd_clk` stay 0. The outputs are enabled, and the clocks come from outside.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; also the clock of all logic |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| strap_in | input | 4 | Levels read from the dual-function pins |
| strap_oe | output | 4 | Output enables of the dual-function pins |
| cpu_clk | output | N_CPU | CPU clock group |
| cpu_oe | output | 1 | CPU group output enable |
| bus_clk | output | N_BUS | Bus clock group |
| bus_oe | output | 1 | Bus group output enable |
| usb_clk | output | 1 | 48 MHz fixed clock output |
| fd_clk | output | 1 | 24 MHz fixed clock output |
| fix_oe | output | 1 | Enable for the two fixed clocks |
| ref_clk | output | 1 | Reference pass-through output |
| ref_oe | output | 1 | Reference output enable |
| mode_o | output | 2 | 00 normal, 01 test, 10 all off |
| cpu_idx | output | 3 | Normal-mode CPU frequency index |
| bus_sync | output | 1 | 1 = bus locked to CPU/2, 0 = fixed rate |

## Verification
The decoded mode, index and bus-sync flag come straight from the register, so they are valid in the first cycle after release. The enables and all divider outputs change on the first rising edge after release. The bench releases reset on a falling edge and then samples 1 ns after every rising and every falling edge. It compares each half-cycle sample with a pattern built from the divide ratio (a sample at half-cycle h is high when h mod 2N < N). This also covers the falling-edge step of the divide-by-3 output. Straps are flipped right after release, so every later sample also checks that the register ignores them.

// File: rtl/strap_pkg.sv
// Shared types for the strap capture and clock mode controller.
package strap_pkg;

    // Operating state decoded from the latched frequency select code.
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_OFF    = 2'b10
    } mode_e;

    // Strap register layout; bit 0 is the bus select, bits 3:1 are FS2:FS0.
    typedef struct packed {
        logic [2:0] fs;
        logic       bsel;
    } strap_t;

    localparam logic [2:0] FS_TEST = 3'b011;
    localparam logic [2:0] FS_OFF  = 3'b111;

endpackage

// File: rtl/strap_latch.sv
// Strap register and run flag.
// While rst_n is low the register follows the pins on every edge, so it
// holds the level present in the final reset cycle. Once rst_n is high the
// register is frozen until the next reset. run_o rises on the first edge
// after release. Assumes rst_n is synchronous to clk.
module strap_latch
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pins_i,
    output strap_t     cfg_o,
    output logic       run_o
);

    // Sample the pins during reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= strap_t'(pins_i);
        end
    end

    // Output-stage permission: low in reset, high from the first free edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= 1'b0;
        end else begin
            run_o <= 1'b1;
        end
    end

endmodule

// File: rtl/mode_decode.sv
// Combinational decode of the strap register into mode, CPU frequency
// index and bus synchronisation flag. The six normal codes are packed into
// indices 0..5 by skipping the test code 011. Assumes a stable input.
module mode_decode
    import strap_pkg::*;
(
    input  strap_t     cfg_i,
    output mode_e      mode_o,
    output logic [2:0] idx_o,
    output logic       sync_o
);

    // Classify the code and derive index and bus flag.
    always_comb begin
        mode_o = MODE_NORMAL;
        idx_o  = 3'd0;
        sync_o = 1'b0;
        if (cfg_i.fs == FS_OFF) begin
            mode_o = MODE_OFF;
        end else if (cfg_i.fs == FS_TEST) begin
            mode_o = MODE_TEST;
        end else begin
            idx_o  = (cfg_i.fs < FS_TEST) ? cfg_i.fs : (cfg_i.fs - 3'd1);
            sync_o = cfg_i.bsel;
        end
    end

endmodule

// File: rtl/ref_div_even.sv
// Even integer divider of the reference clock with a registered output.
// Reset parks the counter on its last count, so the output rises on the
// first edge after release. Every instance shares that phase, which keeps
// dividers of related ratios aligned. Assumes DIV is even and at least 2.
module ref_div_even #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_o
);

    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;

    // Next count with wrap at DIV-1.
    always_comb begin
        nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Count and register the high phase (first half of each period).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= LAST;
            clk_o <= 1'b0;
        end else begin
            cnt   <= nxt;
            clk_o <= (32'(nxt) < HALF);
        end
    end

endmodule

// File: rtl/ref_div_three.sv
// Divide-by-3 of the reference clock with 50% duty cycle.
// A rising-edge flop is high for one cycle in three, and a falling-edge
// copy stretches it by half a cycle, so the OR of the two is high for 1.5
// cycles. The output rises on the first edge after release, in phase with
// the even dividers. Assumes rst_n is synchronous to the rising edge.
module ref_div_three (
    input  logic clk,
    input  logic rst_n,
    output logic clk_o
);

    logic [1:0] cnt;
    logic [1:0] nxt;
    logic       hi_pos;
    logic       hi_neg;

    // Next count, wrapping after 2.
    always_comb begin
        nxt = (cnt == 2'd2) ? 2'd0 : cnt + 2'd1;
    end

    // Rising-edge phase: high during count 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= 2'd2;
            hi_pos <= 1'b0;
        end else begin
            cnt    <= nxt;
            hi_pos <= (nxt == 2'd0);
        end
    end

    // Falling-edge copy that adds the extra half cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            hi_neg <= 1'b0;
        end else begin
            hi_neg <= hi_pos;
        end
    end

    assign clk_o = hi_pos | hi_neg;

endmodule

// File: rtl/strap_clock_ctrl.sv
// Top of the strap capture and clock mode controller.
// Captures the four strap levels during power-on reset, decodes them, and
// then enables the output groups. In test mode it drives every group from
// reference dividers; in normal mode it reports the selection and holds the
// synthesised clock ports low. The off code keeps every driver disabled.
// Assumes clk_ref is the reference and rst_n is synchronous to it.
module strap_clock_ctrl
    import strap_pkg::*;
#(
    parameter int N_CPU    = 12,
    parameter int N_BUS    = 6,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [3:0]       strap_in,
    output logic [3:0]       strap_oe,
    output logic [N_CPU-1:0] cpu_clk,
    output logic             cpu_oe,
    output logic [N_BUS-1:0] bus_clk,
    output logic             bus_oe,
    output logic             usb_clk,
    output logic             fd_clk,
    output logic             fix_oe,
    output logic             ref_clk,
    output logic             ref_oe,
    output logic [1:0]       mode_o,
    output logic [2:0]       cpu_idx,
    output logic             bus_sync
);

    strap_t     cfg;
    logic       run;
    mode_e      mode;
    logic [2:0] idx;
    logic       sync;
    logic       div_fast;
    logic       div_slow;
    logic       div_three;
    logic       drive_on;
    logic       test_on;
    logic       bus_src;

    strap_latch u_latch (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .pins_i (strap_in),
        .cfg_o  (cfg),
        .run_o  (run)
    );

    mode_decode u_dec (
        .cfg_i  (cfg),
        .mode_o (mode),
        .idx_o  (idx),
        .sync_o (sync)
    );

    ref_div_even #(.DIV(FAST_DIV)) u_div_fast (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .clk_o (div_fast)
    );

    ref_div_even #(.DIV(SLOW_DIV)) u_div_slow (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .clk_o (div_slow)
    );

    ref_div_three u_div_three (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .clk_o (div_three)
    );

    // Driver permission and test-mode gate.
    always_comb begin
        drive_on = run && (mode != MODE_OFF);
        test_on  = run && (mode == MODE_TEST);
        bus_src  = cfg.bsel ? div_slow : div_three;
    end

    // Fan the divided clocks out to each CPU and bus output.
    for (genvar gi = 0; gi < N_CPU; gi++) begin : g_cpu
        assign cpu_clk[gi] = test_on & div_fast;
    end
    for (genvar gj = 0; gj < N_BUS; gj++) begin : g_bus
        assign bus_clk[gj] = test_on & bus_src;
    end

    assign usb_clk  = test_on & div_fast;
    assign fd_clk   = test_on & div_slow;
    assign ref_clk  = drive_on & clk_ref;

    assign cpu_oe   = drive_on;
    assign bus_oe   = drive_on;
    assign fix_oe   = drive_on;
    assign ref_oe   = drive_on;
    assign strap_oe = {4{drive_on}};

    assign mode_o   = mode;
    assign cpu_idx  = idx;
    assign bus_sync = sync;

endmodule

// File: rtl/strap_clock_ctrl_chk.sv
// Assertion checker for strap_clock_ctrl, attached with bind.
// Observes ports only; assumes the same clock and reset as the design.
module strap_clock_ctrl_chk #(
    parameter int N_CPU = 12,
    parameter int N_BUS = 6
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic [3:0]       strap_oe,
    input logic [N_CPU-1:0] cpu_clk,
    input logic             cpu_oe,
    input logic [N_BUS-1:0] bus_clk,
    input logic             bus_oe,
    input logic             usb_clk,
    input logic             fd_clk,
    input logic             fix_oe,
    input logic             ref_oe,
    input logic [1:0]       mode_o,
    input logic [2:0]       cpu_idx,
    input logic             bus_sync
);

    // R1: the cycle after a reset edge nothing drives
    assert_quiet_in_reset_R1: assert property (@(posedge clk_ref)
        !rst_n |=> (strap_oe == 4'b0) && !cpu_oe && !bus_oe && !fix_oe && !ref_oe
                   && (cpu_clk == '0) && (bus_clk == '0) && !usb_clk && !fd_clk);

    // R2: decoded outputs frozen while running
    assert_cfg_frozen_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o) && $stable(cpu_idx) && $stable(bus_sync));

    // R3: off code keeps every driver disabled
    assert_off_quiet_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_o == 2'b10) |-> !cpu_oe && !bus_oe && !fix_oe && !ref_oe && (strap_oe == 4'b0));

    // R4: test-mode CPU clock toggles on every edge once running
    assert_cpu_toggle_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((mode_o == 2'b01) && $past(rst_n)) |-> (cpu_clk[0] != $past(cpu_clk[0])));

    // R7: index never leaves the six normal slots
    assert_idx_range_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cpu_idx <= 3'd5) && ((mode_o != 2'b00) -> (cpu_idx == 3'd0)));

    // R8: synchronous bus flag only in a normal mode
    assert_sync_normal_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        bus_sync |-> (mode_o == 2'b00));

    // R9: slow divider rises only together with the fast divider
    assert_fd_aligned_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(fd_clk) |-> $rose(cpu_clk[0]));

    // R10: synthesised clock ports stay low in normal mode
    assert_normal_quiet_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (cpu_clk == '0) && (bus_clk == '0) && !usb_clk && !fd_clk);

endmodule

bind strap_clock_ctrl strap_clock_ctrl_chk #(.N_CPU(N_CPU), .N_BUS(N_BUS)) u_chk (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .strap_oe (strap_oe),
    .cpu_clk  (cpu_clk),
    .cpu_oe   (cpu_oe),
    .bus_clk  (bus_clk),
    .bus_oe   (bus_oe),
    .usb_clk  (usb_clk),
    .fd_clk   (fd_clk),
    .fix_oe   (fix_oe),
    .ref_oe   (ref_oe),
    .mode_o   (mode_o),
    .cpu_idx  (cpu_idx),
    .bus_sync (bus_sync)
);

// File: tb/strap_clock_ctrl_test.sv
`timescale 1ns/1ps
// Sweeps all 16 strap values and checks decode, enables and divider waveforms.
module strap_clock_ctrl_test;

    localparam int NC = 12;
    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    strap_in = 4'b0;
    logic [3:0]    strap_oe;
    logic [NC-1:0] cpu_clk;
    logic          cpu_oe;
    logic [NB-1:0] bus_clk;
    logic          bus_oe;
    logic          usb_clk;
    logic          fd_clk;
    logic          fix_oe;
    logic          ref_clk;
    logic          ref_oe;
    logic [1:0]    mode_o;
    logic [2:0]    cpu_idx;
    logic          bus_sync;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strap_clock_ctrl #(.N_CPU(NC), .N_BUS(NB)) uut (
        .clk_ref (clk), .rst_n (rst_n), .strap_in (strap_in), .strap_oe (strap_oe),
        .cpu_clk (cpu_clk), .cpu_oe (cpu_oe), .bus_clk (bus_clk), .bus_oe (bus_oe),
        .usb_clk (usb_clk), .fd_clk (fd_clk), .fix_oe (fix_oe), .ref_clk (ref_clk),
        .ref_oe (ref_oe), .mode_o (mode_o), .cpu_idx (cpu_idx), .bus_sync (bus_sync)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs at half-cycle h after release against the strap value.
    task automatic check_run(input logic [3:0] cfg, input int h);
        int fs;
        int bsel;
        bit off;
        bit tst;
        int e_mode;
        int e_idx;
        int e_fast;
        int e_slow;
        int e_bus;
        int e_ref;
        fs   = int'(cfg[3:1]);
        bsel = int'(cfg[0]);
        off  = (fs == 7);
        tst  = (fs == 3);
        e_mode = off ? 2 : (tst ? 1 : 0);
        e_idx  = (off || tst) ? 0 : ((fs < 3) ? fs : fs - 1);
        e_fast = tst ? int'((h % 4) < 2) : 0;
        e_slow = tst ? int'((h % 8) < 4) : 0;
        e_bus  = tst ? (bsel == 1 ? int'((h % 8) < 4) : int'((h % 6) < 3)) : 0;
        e_ref  = off ? 0 : int'((h % 2) == 0);
        chk(off ? "R3" : "R7", int'(mode_o), e_mode, "mode_o");
        chk("R7", int'(cpu_idx), e_idx, "cpu_idx");
        chk("R8", int'(bus_sync), (!off && !tst && bsel == 1) ? 1 : 0, "bus_sync");
        chk(off ? "R3" : "R9", int'({cpu_oe, bus_oe, fix_oe, ref_oe}), off ? 0 : 15, "group_oe");
        chk(off ? "R3" : "R9", int'(strap_oe), off ? 0 : 15, "strap_oe");
        chk(tst ? "R4" : "R10", int'(cpu_clk), e_fast ? ((1 << NC) - 1) : 0, "cpu_clk");
        chk(tst ? "R4" : "R10", int'(usb_clk), e_fast, "usb_clk");
        chk(tst ? "R4" : "R10", int'(fd_clk), e_slow, "fd_clk");
        chk(tst ? "R5" : "R10", int'(bus_clk), e_bus ? ((1 << NB) - 1) : 0, "bus_clk");
        chk(off ? "R3" : "R6", int'(ref_clk), e_ref, "ref_clk");
    endtask

    initial begin
        for (int code = 0; code < 16; code++) begin
            logic [3:0] cfg;
            cfg = 4'(code);
            @(negedge clk);
            rst_n = 1'b0;
            strap_in = cfg;
            repeat (3) @(posedge clk);
            #1;
            // R1: nothing driven while reset is held
            chk("R1", int'({strap_oe, cpu_oe, bus_oe, fix_oe, ref_oe}), 0, "reset_oe");
            chk("R1", int'({cpu_clk, bus_clk, usb_clk, fd_clk, ref_clk}), 0, "reset_clk");
            @(negedge clk);
            rst_n = 1'b1;
            #2;
            // R2: straps flipped after release must be ignored
            strap_in = ~cfg;
            for (int k = 0; k < 12; k++) begin
                @(posedge clk);
                #1;
                check_run(cfg, 2 * k);
                @(negedge clk);
                #1;
                check_run(cfg, 2 * k + 1);
            end
            chk("R2", int'(mode_o), (cfg[3:1] == 3'b111) ? 2 : ((cfg[3:1] == 3'b011) ? 1 : 0), "mode_after_flip");
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule